// File: doc/BRIEF.md
# Synthesizer Divider Programming Front End

This block sits in front of the divider chain of an integer-N frequency synthesizer. It turns a slow serial bit stream into the divider settings the chain uses. Bits are shifted, most significant first, into one of two shift registers. A 20-bit divider register holds the main (M), swallow (A) and reference (R) counts. An 8-bit register holds optional test features. A level on a register-select pin decides which register receives each bit.

A separate load strobe copies both shift registers into shadow registers. The active counts therefore never change partway through a word. A mode pin chooses the source of the M and A counts. In parallel mode they come straight from dedicated pins. In serial mode they come from the shadow register. A registered output stage makes the switch between the two sources clean.

While an active-low feature enable is held low, two bits of the shadowed feature register route one of three chain taps to a single test output. The three taps are the main counter output, the reference counter output and the prescaler modulus select. When the feature enable is high, all feature outputs read zero.

Top module: `pll_sprog_top`

## Requirements
- R1: In serial mode, each rising edge of `ser_clk` while `feat_wsel` is low shifts `ser_data` into bit 0 of the divider shift register, and the older bits move up one place. The first bit sent therefore ends in bit 19.
- R2: In serial mode, each rising edge of `ser_clk` while `feat_wsel` is high shifts `ser_data` into the 8-bit feature shift register in the same way. The divider shift register keeps its contents.
- R3: A one-cycle `load` pulse in serial mode copies both shift registers into their shadows. Without a load, shifting has no effect on any output.
- R4: While `direct_mode` is 1, `m_val` and `a_val` equal `dir_m` and `dir_a` as sampled at the previous `clk` edge.
- R5: While `direct_mode` is 0, the outputs follow the shadowed divider word one `clk` edge after it changes: `m_val` is bits 8..0, `a_val` is bits 12..9 and `r_val` is bits 19..13. `r_val` follows bits 19..13 in both modes.
- R6: While `direct_mode` is 1, serial clock edges and `load` pulses are ignored. Neither the shift registers nor the shadows change.
- R7: While `feat_en_n` is 0, `test_sel` equals shadowed feature bits 1..0 and `feat_flags` equals feature bits 7..2. `dout` is selected by `test_sel`: 00 gives `tap_main`, 01 gives `tap_rdiv`, 10 gives `tap_msel` and 11 gives 0.
- R8: While `feat_en_n` is 1, `dout`, `test_sel` and `feat_flags` are all 0, whatever the feature register holds.
- R9: A synchronous reset (`rst_n` low at a `clk` edge) clears both shift registers and both shadows. `m_val`, `a_val` and `r_val` then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_clk | input | 1 | Serial bit clock, sampled on `clk` |
| ser_data | input | 1 | Serial data bit |
| feat_wsel | input | 1 | 1 = shift into feature register, 0 = divider register |
| load | input | 1 | One-cycle pulse copying shift registers to shadows |
| direct_mode | input | 1 | 1 = parallel pins, 0 = serial shadow |
| dir_m | input | 9 | Parallel M count |
| dir_a | input | 4 | Parallel A count |
| feat_en_n | input | 1 | Feature enable, active low |
| tap_main | input | 1 | Main counter output tap |
| tap_rdiv | input | 1 | Reference counter output tap |
| tap_msel | input | 1 | Prescaler modulus select tap |
| m_val | output | 9 | Active M count |
| a_val | output | 4 | Active A count |
| r_val | output | 7 | Active R count |
| test_sel | output | 2 | Effective test-output source select |
| feat_flags | output | 6 | Effective remaining feature bits |
| dout | output | 1 | Test data output |

## Verification
The assertions assume a slow serial clock. Each level of `ser_clk` is held for several `clk` cycles, so each edge gives exactly one shift pulse. They also assume that `ser_data` and `feat_wsel` stay steady around that edge, and that `load` does not coincide with a shift. The stimulus holds every serial level for four system clocks and sets the register select before the first bit of a word. It pulses `load` only between words. Words, feature settings, modes and taps are drawn at random from a fixed seed, alongside directed cases for mode switching, unloaded shifts and each output-select code.

// File: rtl/pll_sprog_pkg.sv
// Package: shared widths, field positions and test-output source codes
// for the synthesizer divider programming front end.
package pll_sprog_pkg;
    localparam int PRIM_W = 20;   // divider shift register width
    localparam int FEAT_W = 8;    // feature shift register width
    localparam int M_W    = 9;
    localparam int A_W    = 4;
    localparam int R_W    = 7;
    localparam int M_LSB  = 0;
    localparam int A_LSB  = M_LSB + M_W;
    localparam int R_LSB  = A_LSB + A_W;
    localparam int SEL_W  = 2;
    localparam int FLAG_W = FEAT_W - SEL_W;

    typedef enum logic [SEL_W-1:0] {
        SRC_MAIN = 2'b00,
        SRC_RDIV = 2'b01,
        SRC_MSEL = 2'b10,
        SRC_LOW  = 2'b11
    } dout_src_e;
endpackage

// File: rtl/pll_sprog_sync.sv
// Module: pll_sprog_sync
// Brings asynchronous serial pins into the clk domain through a chain of
// STAGES flops, and flags the rising edge of bit 0 (the serial clock).
// Assumes each serial level is held for more than STAGES+1 clk cycles.
module pll_sprog_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out,
    output logic             edge_rise
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic             prev_q;

    // Synchronizer chain: stage 0 samples the pins, later stages follow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

    // Delayed copy of the synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_out[0];
    end

    assign edge_rise = sync_out[0] & ~prev_q;

    // A rising edge lasts one cycle, so one serial edge gives one shift.
    assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        edge_rise |=> !edge_rise);
endmodule

// File: rtl/pll_sprog_shift.sv
// Module: pll_sprog_shift
// Holds the divider and feature shift registers and their shadows.
// Bits enter at bit 0, so the first bit of a word ends at the MSB.
// Assumes shift_pulse and load never coincide (loads come between words).
module pll_sprog_shift
    import pll_sprog_pkg::*;
#(
    parameter int P_W = PRIM_W,
    parameter int F_W = FEAT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_pulse,
    input  logic           ser_bit,
    input  logic           wsel,
    input  logic           load,
    output logic [P_W-1:0] prim_shadow,
    output logic [F_W-1:0] feat_shadow
);
    logic [P_W-1:0] prim_sr;
    logic [F_W-1:0] feat_sr;

    // Shift one bit into the register chosen by wsel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim_sr <= '0;
            feat_sr <= '0;
        end else if (shift_pulse) begin
            if (wsel) feat_sr <= {feat_sr[F_W-2:0], ser_bit};
            else      prim_sr <= {prim_sr[P_W-2:0], ser_bit};
        end
    end

    // Copy both shift registers to the shadows on a load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim_shadow <= '0;
            feat_shadow <= '0;
        end else if (load) begin
            prim_shadow <= prim_sr;
            feat_shadow <= feat_sr;
        end
    end

    assert_prim_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && !wsel) |=>
            (prim_sr[0] == $past(ser_bit)) &&
            (prim_sr[P_W-1:1] == $past(prim_sr[P_W-2:0])));

    assert_prim_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && wsel) |=>
            $stable(prim_sr) && (feat_sr[0] == $past(ser_bit)));

    assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(prim_shadow) && $stable(feat_shadow));
endmodule

// File: rtl/pll_sprog_out.sv
// Module: pll_sprog_out
// Registered mux for the active counts (parallel pins or shadowed word)
// and the feature-gated test output select. The dout path is
// combinational from the taps so that tap timing passes straight through.
module pll_sprog_out
    import pll_sprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              direct_mode,
    input  logic [M_W-1:0]    dir_m,
    input  logic [A_W-1:0]    dir_a,
    input  logic [PRIM_W-1:0] prim_shadow,
    input  logic [FEAT_W-1:0] feat_shadow,
    input  logic              feat_en_n,
    input  logic              tap_main,
    input  logic              tap_rdiv,
    input  logic              tap_msel,
    output logic [M_W-1:0]    m_val,
    output logic [A_W-1:0]    a_val,
    output logic [R_W-1:0]    r_val,
    output logic [SEL_W-1:0]  test_sel,
    output logic [FLAG_W-1:0] feat_flags,
    output logic              dout
);
    dout_src_e src;

    // Register the active counts so a mode change never glitches them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_val <= '0;
            a_val <= '0;
            r_val <= '0;
        end else begin
            m_val <= direct_mode ? dir_m : prim_shadow[M_LSB +: M_W];
            a_val <= direct_mode ? dir_a : prim_shadow[A_LSB +: A_W];
            r_val <= prim_shadow[R_LSB +: R_W];
        end
    end

    // Feature bits count only while the active-low enable is held low.
    always_comb begin
        test_sel   = feat_en_n ? '0 : feat_shadow[SEL_W-1:0];
        feat_flags = feat_en_n ? '0 : feat_shadow[FEAT_W-1:SEL_W];
        src        = dout_src_e'(test_sel);
    end

    // Route the chosen tap to dout; the gated-off state reads as low.
    always_comb begin
        if (feat_en_n) dout = 1'b0;
        else begin
            unique case (src)
                SRC_MAIN: dout = tap_main;
                SRC_RDIV: dout = tap_rdiv;
                SRC_MSEL: dout = tap_msel;
                SRC_LOW:  dout = 1'b0;
            endcase
        end
    end

    assert_direct_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        direct_mode |=> (m_val == $past(dir_m)) && (a_val == $past(dir_a)));

    assert_serial_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !direct_mode |=> (m_val == $past(prim_shadow[M_LSB +: M_W])) &&
                         (a_val == $past(prim_shadow[A_LSB +: A_W])));
endmodule

// File: rtl/pll_sprog_top.sv
// Module: pll_sprog_top
// Serial/parallel programming front end of an integer-N synthesizer.
// Samples the serial pins on clk, gates shifting and loading off in
// parallel mode, and presents the active counts and test output.
module pll_sprog_top
    import pll_sprog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              feat_wsel,
    input  logic              load,
    input  logic              direct_mode,
    input  logic [M_W-1:0]    dir_m,
    input  logic [A_W-1:0]    dir_a,
    input  logic              feat_en_n,
    input  logic              tap_main,
    input  logic              tap_rdiv,
    input  logic              tap_msel,
    output logic [M_W-1:0]    m_val,
    output logic [A_W-1:0]    a_val,
    output logic [R_W-1:0]    r_val,
    output logic [SEL_W-1:0]  test_sel,
    output logic [FLAG_W-1:0] feat_flags,
    output logic              dout
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] pins_sync;
    logic              ser_rise;
    logic              shift_pulse;
    logic              load_ok;
    logic [PRIM_W-1:0] prim_shadow;
    logic [FEAT_W-1:0] feat_shadow;

    pll_sprog_sync #(.STAGES(SYNC_STAGES), .WIDTH(SYNC_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({feat_wsel, ser_data, ser_clk}),
        .sync_out (pins_sync),
        .edge_rise(ser_rise)
    );

    // The serial path is idle while the parallel pins are in charge.
    assign shift_pulse = ser_rise & ~direct_mode;
    assign load_ok     = load & ~direct_mode;

    pll_sprog_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_pulse(shift_pulse),
        .ser_bit    (pins_sync[1]),
        .wsel       (pins_sync[2]),
        .load       (load_ok),
        .prim_shadow(prim_shadow),
        .feat_shadow(feat_shadow)
    );

    pll_sprog_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .direct_mode(direct_mode),
        .dir_m      (dir_m),
        .dir_a      (dir_a),
        .prim_shadow(prim_shadow),
        .feat_shadow(feat_shadow),
        .feat_en_n  (feat_en_n),
        .tap_main   (tap_main),
        .tap_rdiv   (tap_rdiv),
        .tap_msel   (tap_msel),
        .m_val      (m_val),
        .a_val      (a_val),
        .r_val      (r_val),
        .test_sel   (test_sel),
        .feat_flags (feat_flags),
        .dout       (dout)
    );

    assert_direct_ignores_serial_R6: assert property (@(posedge clk) disable iff (!rst_n)
        direct_mode |=> $stable(prim_shadow) && $stable(feat_shadow));

    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (m_val == '0) && (a_val == '0) && (r_val == '0) &&
                   (prim_shadow == '0) && (feat_shadow == '0));
endmodule

// File: tb/pll_sprog_top_tb.sv
// Bench for pll_sprog_top: a fixed-seed random mix of words and modes,
// plus directed corner cases, checked against a bench-side model.
module pll_sprog_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_data = 1'b0, feat_wsel = 1'b0, load = 1'b0;
    logic       direct_mode = 1'b0;
    logic [8:0] dir_m = '0;
    logic [3:0] dir_a = '0;
    logic       feat_en_n = 1'b1;
    logic       tap_main = 1'b0, tap_rdiv = 1'b0, tap_msel = 1'b0;
    logic [8:0] m_val;
    logic [3:0] a_val;
    logic [6:0] r_val;
    logic [1:0] test_sel;
    logic [5:0] feat_flags;
    logic       dout;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench model of shift registers and shadows.
    logic [19:0] m_prim_sr = '0, m_prim_sh = '0;
    logic [7:0]  m_feat_sr = '0, m_feat_sh = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_sprog_top dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .feat_wsel(feat_wsel), .load(load), .direct_mode(direct_mode),
        .dir_m(dir_m), .dir_a(dir_a), .feat_en_n(feat_en_n),
        .tap_main(tap_main), .tap_rdiv(tap_rdiv), .tap_msel(tap_msel),
        .m_val(m_val), .a_val(a_val), .r_val(r_val), .test_sel(test_sel),
        .feat_flags(feat_flags), .dout(dout)
    );

    function automatic logic exp_dout(logic en_n, logic [1:0] sel,
                                      logic tm, logic tr, logic ts);
        if (en_n) return 1'b0;
        case (sel)
            2'b00:   return tm;
            2'b01:   return tr;
            2'b10:   return ts;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string req, string what, int actual, int expected);
        n_cmp++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
        end
    endtask

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        ser_data = b;
        wait_clks(HOLD);
        ser_clk = 1'b1;
        wait_clks(HOLD);
        ser_clk = 1'b0;
        wait_clks(HOLD);
    endtask

    // Send a word MSB first into the selected register and update the model.
    task automatic send_word(logic [19:0] word, int width, logic to_feat);
        feat_wsel = to_feat;
        wait_clks(HOLD);
        for (int i = width - 1; i >= 0; i--) begin
            send_bit(word[i]);
            if (!direct_mode) begin
                if (to_feat) m_feat_sr = {m_feat_sr[6:0], word[i]};
                else         m_prim_sr = {m_prim_sr[18:0], word[i]};
            end
        end
    endtask

    task automatic pulse_load();
        load = 1'b1;
        wait_clks(1);
        load = 1'b0;
        if (!direct_mode) begin
            m_prim_sh = m_prim_sr;
            m_feat_sh = m_feat_sr;
        end
        wait_clks(3);
    endtask

    task automatic check_counts(string req);
        logic [8:0] em;
        logic [3:0] ea;
        em = direct_mode ? dir_m : m_prim_sh[8:0];
        ea = direct_mode ? dir_a : m_prim_sh[12:9];
        check(req, "m_val", int'(m_val), int'(em));
        check(req, "a_val", int'(a_val), int'(ea));
        check(req, "r_val", int'(r_val), int'(m_prim_sh[19:13]));
    endtask

    task automatic check_feat(string req);
        #1;
        check(req, "test_sel", int'(test_sel), feat_en_n ? 0 : int'(m_feat_sh[1:0]));
        check(req, "feat_flags", int'(feat_flags), feat_en_n ? 0 : int'(m_feat_sh[7:2]));
        check(req, "dout", int'(dout),
              int'(exp_dout(feat_en_n, m_feat_sh[1:0], tap_main, tap_rdiv, tap_msel)));
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7354));
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(2);
        // R9: reset state.
        check("R9", "m_val", int'(m_val), 0);
        check("R9", "a_val", int'(a_val), 0);
        check("R9", "r_val", int'(r_val), 0);

        // R1/R5: first bit ends at bit 19; known layout.
        send_word(20'h8_0A05, 20, 1'b0);
        // R3: no load yet, outputs unchanged.
        check_counts("R3");
        pulse_load();
        check("R1", "r_val msb", int'(r_val), 7'h40);
        check_counts("R5");

        // R2: feature word leaves the divider word alone.
        send_word(20'h000C6, 8, 1'b1);
        pulse_load();
        check_counts("R2");
        feat_en_n = 1'b0;
        tap_main = 1'b1; tap_rdiv = 1'b0; tap_msel = 1'b1;
        check_feat("R7");
        feat_en_n = 1'b1;
        check_feat("R8");

        // R7: each source code in turn.
        for (int s = 0; s < 4; s++) begin
            send_word(20'(s) | 20'h8C, 8, 1'b1);
            pulse_load();
            feat_en_n = 1'b0;
            for (int t = 0; t < 8; t++) begin
                {tap_main, tap_rdiv, tap_msel} = 3'(t);
                check_feat("R7");
            end
            feat_en_n = 1'b1;
        end

        // R4/R6: parallel mode follows pins, serial traffic ignored.
        direct_mode = 1'b1;
        dir_m = 9'h1A5; dir_a = 4'hB;
        wait_clks(2);
        check_counts("R4");
        send_word(20'hF_FFFF, 20, 1'b0);
        pulse_load();
        check_counts("R6");
        direct_mode = 1'b0;
        wait_clks(2);
        check_counts("R6");
        pulse_load();
        check_counts("R6");

        // Random mix.
        for (int it = 0; it < 40; it++) begin
            logic [19:0] w;
            w = 20'($urandom);
            direct_mode = ($urandom % 4) == 0;
            dir_m = 9'($urandom);
            dir_a = 4'($urandom);
            if ($urandom % 2) send_word(w, 20, 1'b0);
            else              send_word(20'($urandom), 8, 1'b1);
            if ($urandom % 4 != 0) pulse_load();
            else                   wait_clks(3);
            check_counts(direct_mode ? "R4" : "R5");
            feat_en_n = 1'($urandom);
            {tap_main, tap_rdiv, tap_msel} = 3'($urandom);
            check_feat(feat_en_n ? "R8" : "R7");
        end

        // R9: reset in the middle of use clears everything.
        direct_mode = 1'b0;
        rst_n = 1'b0;
        wait_clks(2);
        rst_n = 1'b1;
        m_prim_sr = '0; m_prim_sh = '0; m_feat_sr = '0; m_feat_sh = '0;
        wait_clks(2);
        check_counts("R9");
        pulse_load();
        check_counts("R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule